// File: doc/BRIEF.md
# Seven-slot serial lane deserializer with clock-pattern framing

This block sits behind the line receivers of a display link. The source sends four serial data lanes and one forwarded clock lane. A clock that runs seven times faster than the pixel rate, and that is phase-aligned to the forwarded clock, is supplied from outside. On each edge of that fast clock the block samples one bit from every lane, so each lane delivers seven bit slots per pixel period. The block finds where each pixel word starts by looking for a fixed shape on the clock lane. Once framing is trusted, it rebuilds the 28-bit parallel word every pixel period: 24 colour bits (8 red, 8 green, 8 blue), line sync, frame sync, data enable and one spare bit. It drives that word out together with a regenerated pixel clock whose falling edge is the strobe for the word.

The output side is a stream with a valid signal and no ready. A serial link cannot be paused, so the consumer must take each word in the cycle that `pix_valid` is high; back-pressure is not supported. Until framing is trusted, and whenever the active-low power-down input is low, every output is held low. Pixel rates of 20 to 65 MHz are the intended range; the block itself only counts fast-clock cycles.

Top module: `lvds7_deser`

## Requirements
- R1: Output bit 7k+j carries lane k, slot j, where slot 0 is the first bit received in a word and slot 6 is the last.
- R2: The clock lane must show 1,1,0,0,0,1,1 (in order of arrival) at the same offset for 4 consecutive words. `locked` then rises on the fast-clock edge that samples slot 0 of the next word.
- R3: While `locked` is low, `pix_data`, `pix_valid` and `pix_clk` are all low.
- R4: While locked, a single word with no clock pattern is tolerated. Two consecutive such words drop `locked` and restart the search. The word that restarts the search counts as the first of the 4 that are needed again.
- R5: While `pwr_n` is low, every output is low from the next edge onward, and framing restarts from search.
- R6: While locked, `pix_clk` is high for 4 fast-clock cycles and low for 3. It rises on the same edge that updates `pix_data`, and `pix_data` does not change at any other time.
- R7: `pix_valid` is high for exactly one fast-clock cycle per word, aligned with the rising edge of `pix_clk`.
- R8: A missing pattern during the confirmation run sends the framer back to search, so the count restarts at the new offset.
- R9: After reset, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Seven-times bit clock, aligned to the forwarded clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_n | input | 1 | Active-low power-down |
| lane_in | input | 4 | One serial bit per data lane |
| clk_lane_in | input | 1 | Serial bit from the forwarded clock lane |
| pix_data | output | 28 | Rebuilt parallel word |
| pix_valid | output | 1 | One-cycle pulse when a new word is presented |
| pix_clk | output | 1 | Regenerated pixel clock; falling edge is the strobe |
| locked | output | 1 | Framing confirmed |

## Verification
The bench builds the block with its default parameters: four lanes, seven slots, a confirmation run of four words and a drop threshold of two misses. Because both thresholds are this small, lock, loss of lock and relock each happen within a handful of words. The bench can therefore check the exact word in which `locked` changes, and a three-bit slip in the stream shows that confirmation restarts rather than carrying its count over. Single-bit patterns at bit 0 and bit 27 pin down the two ends of the lane-to-bit map.

// File: rtl/lvds7_pkg.sv
package lvds7_pkg;
  typedef enum logic [1:0] {
    ST_SEARCH = 2'd0,
    ST_VERIFY = 2'd1,
    ST_LOCKED = 2'd2
  } frame_st_t;
endpackage

// File: rtl/lvds7_shift.sv
// Serial-in window: newest bit enters at the LSB, oldest sits at the MSB.
module lvds7_shift #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= {q[W-2:0], din};
  end
endmodule

// File: rtl/lvds7_framer.sv
// Finds the word boundary from the clock-lane window and qualifies it.
module lvds7_framer
  import lvds7_pkg::*;
#(
  parameter int             SLOTS      = 7,
  parameter logic [SLOTS-1:0] PATTERN  = 7'b1100011,
  parameter int             LOCK_WORDS = 4,
  parameter int             DROP_WORDS = 2,
  localparam int            PH_W       = $clog2(SLOTS),
  localparam int            HW         = $clog2(LOCK_WORDS + 1),
  localparam int            MW         = $clog2(DROP_WORDS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_n,
  input  logic [SLOTS-1:0] win,
  output logic             bnd,
  output logic             locked,
  output logic [PH_W-1:0]  phase
);
  frame_st_t       st;
  logic [HW-1:0]   hits;
  logic [MW-1:0]   miss;
  logic            hit;

  assign hit    = (win == PATTERN);
  assign bnd    = (phase == PH_W'(SLOTS - 1));
  assign locked = (st == ST_LOCKED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_SEARCH;
      phase <= '0;
      hits  <= '0;
      miss  <= '0;
    end else if (!pwr_n) begin
      st    <= ST_SEARCH;
      phase <= '0;
      hits  <= '0;
      miss  <= '0;
    end else begin
      phase <= bnd ? '0 : phase + PH_W'(1);
      case (st)
        ST_SEARCH: begin
          if (hit) begin
            phase <= '0;
            hits  <= HW'(1);
            miss  <= '0;
            st    <= (LOCK_WORDS == 1) ? ST_LOCKED : ST_VERIFY;
          end
        end
        ST_VERIFY: begin
          if (bnd) begin
            if (hit) begin
              hits <= hits + HW'(1);
              if (hits == HW'(LOCK_WORDS - 1)) st <= ST_LOCKED;
            end else begin
              hits <= '0;
              st   <= ST_SEARCH;
            end
          end
        end
        ST_LOCKED: begin
          if (bnd) begin
            if (hit) begin
              miss <= '0;
            end else if (miss == MW'(DROP_WORDS - 1)) begin
              miss <= '0;
              hits <= '0;
              st   <= ST_SEARCH;
            end else begin
              miss <= miss + MW'(1);
            end
          end
        end
        default: st <= ST_SEARCH;
      endcase
    end
  end

  // R2: lock only follows a boundary that carried the pattern
  p_lock_after_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(bnd && hit));

  // R4: lock lost without power-down only after a boundary that missed
  p_drop_after_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(locked) && $past(pwr_n)) |-> $past(bnd && !hit));

  // R8: a confirmation run always holds between one and LOCK_WORDS-1 hits
  p_verify_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_VERIFY) |-> (hits != '0 && hits < HW'(LOCK_WORDS)));

  // R6: slot counter stays inside one word
  p_phase_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    phase < PH_W'(SLOTS));
endmodule

// File: rtl/lvds7_unpack.sv
// Reorders the lane windows into the parallel word and shapes the pixel clock.
module lvds7_unpack #(
  parameter int  LANES = 4,
  parameter int  SLOTS = 7,
  localparam int NBITS = LANES * SLOTS,
  localparam int PH_W  = $clog2(SLOTS),
  localparam int HIGH  = (SLOTS + 1) / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_n,
  input  logic             locked,
  input  logic             bnd,
  input  logic [PH_W-1:0]  phase,
  input  logic [NBITS-1:0] win_flat,
  output logic [NBITS-1:0] word,
  output logic             valid,
  output logic             pclk
);
  logic [NBITS-1:0] mapped;
  logic             fall;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    for (genvar j = 0; j < SLOTS; j++) begin : g_slot
      assign mapped[k*SLOTS + j] = win_flat[k*SLOTS + SLOTS - 1 - j];
    end
  end

  assign fall = (phase == PH_W'(HIGH - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word  <= '0;
      valid <= 1'b0;
      pclk  <= 1'b0;
    end else if (!pwr_n || !locked) begin
      word  <= '0;
      valid <= 1'b0;
      pclk  <= 1'b0;
    end else begin
      valid <= bnd;
      if (bnd) begin
        word <= mapped;
        pclk <= 1'b1;
      end else if (fall) begin
        pclk <= 1'b0;
      end
    end
  end

  // R3: outputs are quiet whenever framing is not confirmed
  p_idle_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |=> (word == '0 && !valid && !pclk));

  // R6: the word holds between boundaries
  p_hold_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && pwr_n && !bnd) |=> $stable(word));

  // R7: each rising edge of the pixel clock comes with a valid pulse
  p_clk_rise_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pclk) |-> valid);
endmodule

// File: rtl/lvds7_deser.sv
module lvds7_deser #(
  parameter int               LANES      = 4,
  parameter int               SLOTS      = 7,
  parameter logic [SLOTS-1:0] PATTERN    = 7'b1100011,
  parameter int               LOCK_WORDS = 4,
  parameter int               DROP_WORDS = 2,
  localparam int              NBITS      = LANES * SLOTS,
  localparam int              PH_W       = $clog2(SLOTS)
) (
  input  logic             clk_bit,
  input  logic             rst_n,
  input  logic             pwr_n,
  input  logic [LANES-1:0] lane_in,
  input  logic             clk_lane_in,
  output logic [NBITS-1:0] pix_data,
  output logic             pix_valid,
  output logic             pix_clk,
  output logic             locked
);
  logic [NBITS-1:0] win_flat;
  logic [SLOTS-1:0] clk_win;
  logic             bnd;
  logic [PH_W-1:0]  phase;

  for (genvar k = 0; k < LANES; k++) begin : g_data
    lvds7_shift #(.W(SLOTS)) u_shift (
      .clk  (clk_bit),
      .rst_n(rst_n),
      .din  (lane_in[k]),
      .q    (win_flat[k*SLOTS +: SLOTS])
    );
  end

  lvds7_shift #(.W(SLOTS)) u_clk_shift (
    .clk  (clk_bit),
    .rst_n(rst_n),
    .din  (clk_lane_in),
    .q    (clk_win)
  );

  lvds7_framer #(
    .SLOTS     (SLOTS),
    .PATTERN   (PATTERN),
    .LOCK_WORDS(LOCK_WORDS),
    .DROP_WORDS(DROP_WORDS)
  ) u_framer (
    .clk   (clk_bit),
    .rst_n (rst_n),
    .pwr_n (pwr_n),
    .win   (clk_win),
    .bnd   (bnd),
    .locked(locked),
    .phase (phase)
  );

  lvds7_unpack #(
    .LANES(LANES),
    .SLOTS(SLOTS)
  ) u_unpack (
    .clk     (clk_bit),
    .rst_n   (rst_n),
    .pwr_n   (pwr_n),
    .locked  (locked),
    .bnd     (bnd),
    .phase   (phase),
    .win_flat(win_flat),
    .word    (pix_data),
    .valid   (pix_valid),
    .pclk    (pix_clk)
  );

  // R5: power-down silences every output on the following edge
  p_pd_quiet_r5: assert property (@(posedge clk_bit) disable iff (!rst_n)
    !pwr_n |=> (pix_data == '0 && !pix_valid && !pix_clk && !locked));
endmodule

// File: tb/lvds7_deser_tb.sv
module lvds7_deser_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;

  typedef struct packed {
    logic [6:0]  pat;
    logic [27:0] data;
    logic        exp_lock;
    logic [27:0] exp_word;
  } vec_t;

  // Words 0..3 confirm framing (R2), lock shows after word 4, and each word
  // is presented one word after it was received (R1).
  localparam vec_t VECS [NV] = '{
    '{7'b1100011, 28'h1234567, 1'b0, 28'h0000000},
    '{7'b1100011, 28'hABCDEF0, 1'b0, 28'h0000000},
    '{7'b1100011, 28'h0F0F0F0, 1'b0, 28'h0000000},
    '{7'b1100011, 28'hFFFFFFF, 1'b0, 28'h0000000},
    '{7'b1100011, 28'h5A5A5A5, 1'b1, 28'h0000000},
    '{7'b1100011, 28'h0000001, 1'b1, 28'h5A5A5A5},
    '{7'b1100011, 28'h8000000, 1'b1, 28'h0000001},
    '{7'b1100011, 28'hC3C3C3C, 1'b1, 28'h8000000}
  };
  localparam logic [6:0] GOOD = 7'b1100011;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwr_n = 1'b1;
  logic [3:0]  lane_in = '0;
  logic        clk_lane_in = 1'b0;
  logic [27:0] pix_data;
  logic        pix_valid, pix_clk, locked;

  int checks = 0;
  int errors = 0;
  logic [6:0] pc_tr, vl_tr;

  always #(CLK_PERIOD/2) clk = ~clk;

  lvds7_deser u_dut (
    .clk_bit    (clk),
    .rst_n      (rst_n),
    .pwr_n      (pwr_n),
    .lane_in    (lane_in),
    .clk_lane_in(clk_lane_in),
    .pix_data   (pix_data),
    .pix_valid  (pix_valid),
    .pix_clk    (pix_clk),
    .locked     (locked)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_word(input logic [6:0] pat, input logic [27:0] d);
    for (int j = 0; j < 7; j++) begin
      @(negedge clk);
      for (int k = 0; k < 4; k++) lane_in[k] = d[7*k + j];
      clk_lane_in = pat[6-j];
      @(posedge clk);
      #1;
      pc_tr[j] = pix_clk;
      vl_tr[j] = pix_valid;
    end
  endtask

  task automatic send_stuff(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lane_in = '0;
      clk_lane_in = 1'b0;
      @(posedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state
    chk("R9 data", 32'(pix_data), 32'h0);
    chk("R9 flags", {29'b0, pix_valid, pix_clk, locked}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // Table walk: R1, R2, R3
    for (int v = 0; v < NV; v++) begin
      send_word(VECS[v].pat, VECS[v].data);
      chk("R2 locked", 32'(locked), 32'(VECS[v].exp_lock));
      chk("R1 word", 32'(pix_data), 32'(VECS[v].exp_word));
      if (!VECS[v].exp_lock) chk("R3 quiet", {30'b0, pix_valid, pix_clk}, 32'h0);
    end

    // R6, R7: clock shape and valid pulse over one word
    send_word(GOOD, 28'h2468ACE);
    chk("R6 pix_clk shape", 32'(pc_tr), 32'h0F);
    chk("R7 valid pulse", 32'(vl_tr), 32'h01);
    chk("R1 word", 32'(pix_data), 32'hC3C3C3C);

    // R4: single miss tolerated
    send_word(7'b0, 28'h1111111);
    send_word(GOOD, 28'h2222222);
    chk("R4 single miss keeps lock", 32'(locked), 32'h1);
    chk("R4 word during miss", 32'(pix_data), 32'h1111111);

    // R4: two misses drop lock
    send_word(7'b0, 28'h3333333);
    send_word(7'b0, 28'h4444444);
    send_word(GOOD, 28'h5555555);
    chk("R4 double miss drops lock", 32'(locked), 32'h0);
    chk("R3 data zero after drop", 32'(pix_data), 32'h0);
    send_word(GOOD, 28'h6666666);
    send_word(GOOD, 28'h7777777);
    send_word(GOOD, 28'h0ABCDEF);
    chk("R4 relock search not yet", 32'(locked), 32'h0);
    send_word(GOOD, 28'h0FEDCBA);
    chk("R4 relock after restart", 32'(locked), 32'h1);

    // R5: power-down
    @(negedge clk);
    pwr_n = 1'b0;
    @(posedge clk);
    @(posedge clk);
    #1;
    chk("R5 data low", 32'(pix_data), 32'h0);
    chk("R5 flags low", {29'b0, pix_valid, pix_clk, locked}, 32'h0);
    @(negedge clk);
    pwr_n = 1'b1;

    // R8: slip of three bits during confirmation restarts the count
    send_word(GOOD, 28'h0101010);
    send_word(GOOD, 28'h0202020);
    send_stuff(3);
    send_word(GOOD, 28'h0303030);
    send_word(GOOD, 28'h0404040);
    send_word(GOOD, 28'h0505050);
    chk("R8 count restarted", 32'(locked), 32'h0);
    send_word(GOOD, 28'h0606060);
    send_word(GOOD, 28'h7654321);
    chk("R8 lock at new offset", 32'(locked), 32'h1);
    send_word(GOOD, 28'h0000000);
    chk("R8 R1 word at new offset", 32'(pix_data), 32'h7654321);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule